// File: doc/BRIEF.md
# Instruction Field and Control Decoder

This block is a purely combinational decoder for a fixed-length 32-bit load-store instruction set. It takes one instruction word and cuts it into its operand fields: two source register indices, a destination register index, a shift amount, a function code and a 16-bit constant. From the same word it derives the control a datapath needs for that instruction. This covers the instruction class, the ALU operation, whether the second ALU operand is the constant, the register write-back enable and target, the memory read and write strobes with byte width and load extension, and whether signed overflow must raise a trap.

The 16-bit constant is widened to a full data word in one of three ways chosen by the opcode. It can be sign-extended, zero-extended, or placed in the upper half with the lower half cleared. Words whose opcode or function code fall outside the supported subset are flagged as illegal, and every side effect is suppressed for them. The register file, ALU, memory port and exception logic sit outside and consume the outputs directly. Since nothing is registered, all results follow the instruction word in the same cycle.

Top module: `insn_field_decoder`

## Requirements
- R1: Field outputs are always driven from fixed bit positions regardless of legality: rs_idx_o = instr[25:21], rt_idx_o = instr[20:16], rd_idx_o = instr[15:11], shamt_o = instr[10:6], funct_o = instr[5:0]; the opcode is instr[31:26].
- R2: fmt_o is 2'b00 for opcode 0 with a supported function code, 2'b01 for a supported nonzero opcode, and 2'b11 otherwise; illegal_o is 1 exactly when fmt_o is 2'b11.
- R3: With opcode 0, alu_op_o follows the function code: 32 and 33 give 0 (add), 34 and 35 give 1 (subtract), 36 gives 2 (and), 37 gives 3 (or), 38 gives 4 (xor), 39 gives 5 (nor), 0 gives 6 (shift left logical), 2 gives 7 (shift right logical), 3 gives 8 (shift right arithmetic); alu_src_imm_o is 0.
- R4: For the immediate class, alu_src_imm_o is 1 and alu_op_o is 0 for opcodes 8, 9, 35, 32, 36, 43 and 40; it is 2 for opcode 12, 3 for opcode 13, and 9 (pass the second operand) for opcode 15.
- R5: For opcodes 8, 35, 32, 36, 43 and 40, imm_ext_o is instr[15:0] with bit 15 copied into bits 31:16.
- R6: For opcodes 9, 12 and 13, imm_ext_o is instr[15:0] with bits 31:16 zero.
- R7: For opcode 15, imm_ext_o[31:16] is instr[15:0] and imm_ext_o[15:0] is zero.
- R8: imm_ext_o is zero for the register class and for illegal words.
- R9: ovf_trap_o is 1 for function codes 32 and 34 under opcode 0 and for opcode 8, and 0 for every other word (including function codes 33 and 35 and opcode 9).
- R10: reg_we_o is 1 for every legal register-class word and for opcodes 8, 9, 12, 13, 15, 35, 32 and 36; dst_sel_rd_o is 1 for the register class and 0 otherwise; dst_idx_o is rd_idx_o when dst_sel_rd_o is 1 and rt_idx_o otherwise.
- R11: mem_rd_o is 1 for opcodes 35, 32 and 36; mem_we_o is 1 for opcodes 43 and 40; mem_byte_o is 1 for opcodes 32, 36 and 40; load_zext_o is 1 only for opcode 36.
- R12: For an illegal word, reg_we_o, mem_rd_o, mem_we_o, mem_byte_o, load_zext_o, ovf_trap_o, alu_src_imm_o and dst_sel_rd_o are 0 and alu_op_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs_idx_o | output | 5 | First source register index |
| rt_idx_o | output | 5 | Second source or load target register index |
| rd_idx_o | output | 5 | Register-class destination index |
| shamt_o | output | 5 | Shift amount field |
| funct_o | output | 6 | Function code field |
| fmt_o | output | 2 | Instruction class: 00 register, 01 immediate, 11 illegal |
| illegal_o | output | 1 | Word is outside the supported subset |
| alu_op_o | output | 4 | ALU operation select |
| alu_src_imm_o | output | 1 | Second ALU operand is the widened constant |
| imm_ext_o | output | 32 | Widened constant |
| reg_we_o | output | 1 | Register write-back enable |
| dst_sel_rd_o | output | 1 | Write-back target is rd (1) or rt (0) |
| dst_idx_o | output | 5 | Selected write-back register index |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_byte_o | output | 1 | Memory access is one byte wide |
| load_zext_o | output | 1 | Loaded byte is zero-extended |
| ovf_trap_o | output | 1 | Signed overflow of this operation must trap |

## Verification
Every output of this decoder is due in the same cycle as the instruction word that produces it, with no register on any path, so there is zero latency. The bench applies a new word just after each rising edge and compares all outputs against its own behavioural model at the following falling edge. By then the combinational cone has settled and no edge ordering is involved. Directed words cover each supported opcode and function code, negative and positive constants, and several illegal encodings, and a long run of weighted random words follows.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

   localparam int OPC_W = 6;
   localparam int FN_W  = 6;

   typedef enum logic [1:0] {
      FMT_REG = 2'b00,
      FMT_IMM = 2'b01,
      FMT_BAD = 2'b11
   } fmt_e;

   typedef enum logic [3:0] {
      ALU_ADD  = 4'd0,
      ALU_SUB  = 4'd1,
      ALU_AND  = 4'd2,
      ALU_OR   = 4'd3,
      ALU_XOR  = 4'd4,
      ALU_NOR  = 4'd5,
      ALU_SLL  = 4'd6,
      ALU_SRL  = 4'd7,
      ALU_SRA  = 4'd8,
      ALU_PASS = 4'd9
   } alu_e;

   typedef enum logic [1:0] {
      IMMK_NONE  = 2'd0,
      IMMK_SIGN  = 2'd1,
      IMMK_ZERO  = 2'd2,
      IMMK_UPPER = 2'd3
   } immk_e;

   // opcode values
   localparam logic [OPC_W-1:0] OPC_REGCLS = 6'd0;
   localparam logic [OPC_W-1:0] OPC_ADDI   = 6'd8;
   localparam logic [OPC_W-1:0] OPC_ADDIU  = 6'd9;
   localparam logic [OPC_W-1:0] OPC_ANDI   = 6'd12;
   localparam logic [OPC_W-1:0] OPC_ORI    = 6'd13;
   localparam logic [OPC_W-1:0] OPC_LUI    = 6'd15;
   localparam logic [OPC_W-1:0] OPC_LB     = 6'd32;
   localparam logic [OPC_W-1:0] OPC_LW     = 6'd35;
   localparam logic [OPC_W-1:0] OPC_LBU    = 6'd36;
   localparam logic [OPC_W-1:0] OPC_SB     = 6'd40;
   localparam logic [OPC_W-1:0] OPC_SW     = 6'd43;

   // function code values
   localparam logic [FN_W-1:0] FN_SLL  = 6'd0;
   localparam logic [FN_W-1:0] FN_SRL  = 6'd2;
   localparam logic [FN_W-1:0] FN_SRA  = 6'd3;
   localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
   localparam logic [FN_W-1:0] FN_ADDU = 6'd33;
   localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
   localparam logic [FN_W-1:0] FN_SUBU = 6'd35;
   localparam logic [FN_W-1:0] FN_AND  = 6'd36;
   localparam logic [FN_W-1:0] FN_OR   = 6'd37;
   localparam logic [FN_W-1:0] FN_XOR  = 6'd38;
   localparam logic [FN_W-1:0] FN_NOR  = 6'd39;

   typedef struct packed {
      fmt_e  fmt;
      alu_e  alu;
      immk_e immk;
      logic  alu_imm;
      logic  reg_we;
      logic  dst_rd;
      logic  mem_rd;
      logic  mem_we;
      logic  mem_byte;
      logic  load_zext;
      logic  ovf;
   } ctrl_t;

endpackage

// File: rtl/insn_dec_fields.sv
module insn_dec_fields #(
   parameter int XLEN   = 32,
   parameter int REG_AW = 5,
   parameter int IMM_W  = 16
) (
   input  logic [XLEN-1:0]                  word_i,
   output logic [insn_dec_pkg::OPC_W-1:0]   opc_o,
   output logic [REG_AW-1:0]                rs_o,
   output logic [REG_AW-1:0]                rt_o,
   output logic [REG_AW-1:0]                rd_o,
   output logic [REG_AW-1:0]                sh_o,
   output logic [insn_dec_pkg::FN_W-1:0]    fn_o,
   output logic [IMM_W-1:0]                 imm_o
);
   localparam int OPC_LSB = XLEN - insn_dec_pkg::OPC_W;
   localparam int RS_LSB  = OPC_LSB - REG_AW;
   localparam int RT_LSB  = RS_LSB - REG_AW;
   localparam int RD_LSB  = RT_LSB - REG_AW;
   localparam int SH_LSB  = RD_LSB - REG_AW;

   // register-class layout must tile the word exactly
   if (SH_LSB != insn_dec_pkg::FN_W) begin : g_bad_layout
      $error("insn_dec_fields: field widths do not fill the word");
   end
   // the constant must fill everything below rt
   if (RT_LSB != IMM_W) begin : g_bad_imm
      $error("insn_dec_fields: constant width does not match layout");
   end

   assign opc_o = word_i[XLEN-1 -: insn_dec_pkg::OPC_W];
   assign rs_o  = word_i[RS_LSB +: REG_AW];
   assign rt_o  = word_i[RT_LSB +: REG_AW];
   assign rd_o  = word_i[RD_LSB +: REG_AW];
   assign sh_o  = word_i[SH_LSB +: REG_AW];
   assign fn_o  = word_i[0 +: insn_dec_pkg::FN_W];
   assign imm_o = word_i[0 +: IMM_W];

endmodule

// File: rtl/insn_dec_ctrl.sv
module insn_dec_ctrl
   import insn_dec_pkg::*;
(
   input  logic [OPC_W-1:0] opc_i,
   input  logic [FN_W-1:0]  fn_i,
   output ctrl_t            ctrl_o
);

   // register-class operation from the function code
   ctrl_t reg_c;
   always_comb begin
      reg_c         = '0;
      reg_c.fmt     = FMT_REG;
      reg_c.reg_we  = 1'b1;
      reg_c.dst_rd  = 1'b1;
      reg_c.immk    = IMMK_NONE;
      case (fn_i)
         FN_ADD:  begin reg_c.alu = ALU_ADD; reg_c.ovf = 1'b1; end
         FN_ADDU: reg_c.alu = ALU_ADD;
         FN_SUB:  begin reg_c.alu = ALU_SUB; reg_c.ovf = 1'b1; end
         FN_SUBU: reg_c.alu = ALU_SUB;
         FN_AND:  reg_c.alu = ALU_AND;
         FN_OR:   reg_c.alu = ALU_OR;
         FN_XOR:  reg_c.alu = ALU_XOR;
         FN_NOR:  reg_c.alu = ALU_NOR;
         FN_SLL:  reg_c.alu = ALU_SLL;
         FN_SRL:  reg_c.alu = ALU_SRL;
         FN_SRA:  reg_c.alu = ALU_SRA;
         default: begin
            reg_c     = '0;
            reg_c.fmt = FMT_BAD;
         end
      endcase
   end

   // immediate-class operation from the opcode
   ctrl_t imm_c;
   always_comb begin
      imm_c         = '0;
      imm_c.fmt     = FMT_IMM;
      imm_c.alu_imm = 1'b1;
      imm_c.alu     = ALU_ADD;
      imm_c.immk    = IMMK_SIGN;
      case (opc_i)
         OPC_ADDI:  begin imm_c.reg_we = 1'b1; imm_c.ovf = 1'b1; end
         OPC_ADDIU: begin imm_c.reg_we = 1'b1; imm_c.immk = IMMK_ZERO; end
         OPC_ANDI:  begin
            imm_c.reg_we = 1'b1; imm_c.immk = IMMK_ZERO; imm_c.alu = ALU_AND;
         end
         OPC_ORI:   begin
            imm_c.reg_we = 1'b1; imm_c.immk = IMMK_ZERO; imm_c.alu = ALU_OR;
         end
         OPC_LUI:   begin
            imm_c.reg_we = 1'b1; imm_c.immk = IMMK_UPPER; imm_c.alu = ALU_PASS;
         end
         OPC_LW:    begin imm_c.reg_we = 1'b1; imm_c.mem_rd = 1'b1; end
         OPC_LB:    begin
            imm_c.reg_we = 1'b1; imm_c.mem_rd = 1'b1; imm_c.mem_byte = 1'b1;
         end
         OPC_LBU:   begin
            imm_c.reg_we = 1'b1; imm_c.mem_rd = 1'b1; imm_c.mem_byte = 1'b1;
            imm_c.load_zext = 1'b1;
         end
         OPC_SW:    imm_c.mem_we = 1'b1;
         OPC_SB:    begin imm_c.mem_we = 1'b1; imm_c.mem_byte = 1'b1; end
         default:   begin
            imm_c     = '0;
            imm_c.fmt = FMT_BAD;
         end
      endcase
   end

   assign ctrl_o = (opc_i == OPC_REGCLS) ? reg_c : imm_c;

endmodule

// File: rtl/insn_dec_immext.sv
module insn_dec_immext
   import insn_dec_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16
) (
   input  logic [IMM_W-1:0] imm_i,
   input  immk_e            kind_i,
   output logic [XLEN-1:0]  ext_o
);
   localparam int PAD_W = XLEN - IMM_W;

   if (PAD_W <= 0) begin : g_bad_width
      $error("insn_dec_immext: constant must be narrower than the word");
   end

   logic [XLEN-1:0] sext_w, zext_w, upper_w;
   assign sext_w  = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
   assign zext_w  = {{PAD_W{1'b0}}, imm_i};
   assign upper_w = {imm_i, {PAD_W{1'b0}}};

   always_comb begin
      case (kind_i)
         IMMK_SIGN:  ext_o = sext_w;
         IMMK_ZERO:  ext_o = zext_w;
         IMMK_UPPER: ext_o = upper_w;
         default:    ext_o = '0;
      endcase
   end

endmodule

// File: rtl/insn_field_decoder.sv
module insn_field_decoder
   import insn_dec_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int REG_AW      = 5,
   parameter int IMM_W       = 16,
   parameter bit TRAP_ON_OVF = 1'b1
) (
   input  logic [XLEN-1:0]   instr_i,
   output logic [REG_AW-1:0] rs_idx_o,
   output logic [REG_AW-1:0] rt_idx_o,
   output logic [REG_AW-1:0] rd_idx_o,
   output logic [REG_AW-1:0] shamt_o,
   output logic [FN_W-1:0]   funct_o,
   output logic [1:0]        fmt_o,
   output logic              illegal_o,
   output logic [3:0]        alu_op_o,
   output logic              alu_src_imm_o,
   output logic [XLEN-1:0]   imm_ext_o,
   output logic              reg_we_o,
   output logic              dst_sel_rd_o,
   output logic [REG_AW-1:0] dst_idx_o,
   output logic              mem_rd_o,
   output logic              mem_we_o,
   output logic              mem_byte_o,
   output logic              load_zext_o,
   output logic              ovf_trap_o
);

   if (XLEN != OPC_W + 4 * REG_AW + FN_W) begin : g_bad_xlen
      $error("insn_field_decoder: word width does not match field widths");
   end

   logic [OPC_W-1:0] opc_w;
   logic [IMM_W-1:0] imm_w;
   ctrl_t            ctrl_w;

   insn_dec_fields #(
      .XLEN   (XLEN),
      .REG_AW (REG_AW),
      .IMM_W  (IMM_W)
   ) u_fields (
      .word_i (instr_i),
      .opc_o  (opc_w),
      .rs_o   (rs_idx_o),
      .rt_o   (rt_idx_o),
      .rd_o   (rd_idx_o),
      .sh_o   (shamt_o),
      .fn_o   (funct_o),
      .imm_o  (imm_w)
   );

   insn_dec_ctrl u_ctrl (
      .opc_i  (opc_w),
      .fn_i   (funct_o),
      .ctrl_o (ctrl_w)
   );

   insn_dec_immext #(
      .XLEN  (XLEN),
      .IMM_W (IMM_W)
   ) u_immext (
      .imm_i  (imm_w),
      .kind_i (ctrl_w.immk),
      .ext_o  (imm_ext_o)
   );

   assign fmt_o         = ctrl_w.fmt;
   assign illegal_o     = (ctrl_w.fmt == FMT_BAD);
   assign alu_op_o      = ctrl_w.alu;
   assign alu_src_imm_o = ctrl_w.alu_imm;
   assign reg_we_o      = ctrl_w.reg_we;
   assign dst_sel_rd_o  = ctrl_w.dst_rd;
   assign dst_idx_o     = ctrl_w.dst_rd ? rd_idx_o : rt_idx_o;
   assign mem_rd_o      = ctrl_w.mem_rd;
   assign mem_we_o      = ctrl_w.mem_we;
   assign mem_byte_o    = ctrl_w.mem_byte;
   assign load_zext_o   = ctrl_w.load_zext;

   // a build without overflow traps ties the flag off
   if (TRAP_ON_OVF) begin : g_trap
      assign ovf_trap_o = ctrl_w.ovf;
   end else begin : g_notrap
      assign ovf_trap_o = 1'b0;
   end

endmodule

// File: rtl/insn_field_decoder_chk.sv
module insn_field_decoder_chk #(
   parameter int XLEN   = 32,
   parameter int REG_AW = 5,
   parameter int IMM_W  = 16
) (
   input logic [XLEN-1:0]   instr_i,
   input logic [1:0]        fmt_o,
   input logic              illegal_o,
   input logic [XLEN-1:0]   imm_ext_o,
   input logic              reg_we_o,
   input logic              dst_sel_rd_o,
   input logic [REG_AW-1:0] dst_idx_o,
   input logic              mem_rd_o,
   input logic              mem_we_o,
   input logic              ovf_trap_o
);
   localparam int OPC_LSB = XLEN - 6;
   localparam int RT_LSB  = IMM_W;
   localparam int RD_LSB  = IMM_W - REG_AW;

   logic [5:0] opc;
   assign opc = instr_i[XLEN-1:OPC_LSB];

   always_comb begin
      // R2
      fmt_illegal_chk: assert ((fmt_o == 2'b11) == illegal_o);
      if (illegal_o) begin
         // R12
         no_side_effect_chk: assert (!reg_we_o && !mem_we_o && !mem_rd_o && !ovf_trap_o);
      end
      // R11
      mem_excl_chk: assert ($onehot0({mem_rd_o, mem_we_o, reg_we_o && mem_we_o}));
      if (ovf_trap_o) begin
         // R9
         ovf_src_chk: assert (opc == 6'd0 || opc == 6'd8);
      end
      if (opc == 6'd15) begin
         // R7
         upper_low_zero_chk: assert (imm_ext_o[IMM_W-1:0] == '0);
      end
      if (opc == 6'd8) begin
         // R5
         sign_fill_chk: assert (imm_ext_o[XLEN-1:IMM_W] == {(XLEN-IMM_W){instr_i[IMM_W-1]}});
      end
      if (reg_we_o) begin
         // R10
         dst_pick_chk: assert (dst_idx_o == (dst_sel_rd_o ? instr_i[RD_LSB +: REG_AW]
                                                          : instr_i[RT_LSB +: REG_AW]));
      end
   end

endmodule

bind insn_field_decoder insn_field_decoder_chk #(
   .XLEN   (XLEN),
   .REG_AW (REG_AW),
   .IMM_W  (IMM_W)
) u_chk (
   .instr_i      (instr_i),
   .fmt_o        (fmt_o),
   .illegal_o    (illegal_o),
   .imm_ext_o    (imm_ext_o),
   .reg_we_o     (reg_we_o),
   .dst_sel_rd_o (dst_sel_rd_o),
   .dst_idx_o    (dst_idx_o),
   .mem_rd_o     (mem_rd_o),
   .mem_we_o     (mem_we_o),
   .ovf_trap_o   (ovf_trap_o)
);

// File: tb/insn_field_decoder_test.sv
module insn_field_decoder_test;
   localparam int CLK_PERIOD = 10;
   localparam int N_RAND     = 4000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = 32'h0;

   logic [4:0]  rs_idx, rt_idx, rd_idx, shamt, dst_idx;
   logic [5:0]  funct;
   logic [1:0]  fmt;
   logic        illegal, alu_src_imm, reg_we, dst_sel_rd;
   logic        mem_rd, mem_we, mem_byte, load_zext, ovf_trap;
   logic [3:0]  alu_op;
   logic [31:0] imm_ext;

   int compared   = 0;
   int mismatched = 0;
   bit finished   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   insn_field_decoder uut (
      .instr_i       (instr),
      .rs_idx_o      (rs_idx),
      .rt_idx_o      (rt_idx),
      .rd_idx_o      (rd_idx),
      .shamt_o       (shamt),
      .funct_o       (funct),
      .fmt_o         (fmt),
      .illegal_o     (illegal),
      .alu_op_o      (alu_op),
      .alu_src_imm_o (alu_src_imm),
      .imm_ext_o     (imm_ext),
      .reg_we_o      (reg_we),
      .dst_sel_rd_o  (dst_sel_rd),
      .dst_idx_o     (dst_idx),
      .mem_rd_o      (mem_rd),
      .mem_we_o      (mem_we),
      .mem_byte_o    (mem_byte),
      .load_zext_o   (load_zext),
      .ovf_trap_o    (ovf_trap)
   );

   function automatic logic [31:0] mk_r(int rs, int rt, int rd, int sh, int fn);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
   endfunction

   function automatic logic [31:0] mk_i(int op, int rs, int rt, int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s word=%h: actual %h expected %h", req, what, instr, act, exp);
      end
   endtask

   // behavioural reference for one word
   task automatic compare_word(input logic [31:0] w);
      int  op, fn;
      int  e_fmt, e_alu, e_kind;  // kind: 0 none, 1 sign, 2 zero, 3 upper
      bit  e_imm, e_we, e_rd_dst, e_mrd, e_mwe, e_byte, e_zx, e_ovf;
      logic [31:0] e_ext;
      op = int'(w[31:26]);
      fn = int'(w[5:0]);
      e_fmt = 3; e_alu = 0; e_kind = 0;
      e_imm = 0; e_we = 0; e_rd_dst = 0; e_mrd = 0; e_mwe = 0;
      e_byte = 0; e_zx = 0; e_ovf = 0;
      if (op == 0) begin
         e_fmt = 0; e_we = 1; e_rd_dst = 1;
         case (fn)
            32: begin e_alu = 0; e_ovf = 1; end
            33: e_alu = 0;
            34: begin e_alu = 1; e_ovf = 1; end
            35: e_alu = 1;
            36: e_alu = 2;
            37: e_alu = 3;
            38: e_alu = 4;
            39: e_alu = 5;
            0:  e_alu = 6;
            2:  e_alu = 7;
            3:  e_alu = 8;
            default: begin e_fmt = 3; e_we = 0; e_rd_dst = 0; end
         endcase
      end else begin
         e_fmt = 1; e_imm = 1;
         case (op)
            8:  begin e_kind = 1; e_we = 1; e_ovf = 1; end
            9:  begin e_kind = 2; e_we = 1; end
            12: begin e_kind = 2; e_we = 1; e_alu = 2; end
            13: begin e_kind = 2; e_we = 1; e_alu = 3; end
            15: begin e_kind = 3; e_we = 1; e_alu = 9; end
            35: begin e_kind = 1; e_we = 1; e_mrd = 1; end
            32: begin e_kind = 1; e_we = 1; e_mrd = 1; e_byte = 1; end
            36: begin e_kind = 1; e_we = 1; e_mrd = 1; e_byte = 1; e_zx = 1; end
            43: begin e_kind = 1; e_mwe = 1; end
            40: begin e_kind = 1; e_mwe = 1; e_byte = 1; end
            default: begin e_fmt = 3; e_imm = 0; end
         endcase
      end
      case (e_kind)
         1: e_ext = 32'(signed'(w[15:0]));
         2: e_ext = 32'(w[15:0]);
         3: e_ext = w[15:0] * 32'd65536;
         default: e_ext = 32'd0;
      endcase

      // R1 field slicing
      chk("R1", "rs",    32'(rs_idx), 32'(w[25:21]));
      chk("R1", "rt",    32'(rt_idx), 32'(w[20:16]));
      chk("R1", "rd",    32'(rd_idx), 32'(w[15:11]));
      chk("R1", "shamt", 32'(shamt),  32'(w[10:6]));
      chk("R1", "funct", 32'(funct),  32'(w[5:0]));
      // R2 class
      chk("R2", "fmt",     32'(fmt),     32'(e_fmt));
      chk("R2", "illegal", 32'(illegal), 32'(e_fmt == 3));
      // R3 / R4 operation select
      if (e_fmt == 0) chk("R3", "alu_op", 32'(alu_op), 32'(e_alu));
      else            chk("R4", "alu_op", 32'(alu_op), 32'(e_alu));
      if (e_fmt == 0) chk("R3", "alu_src_imm", 32'(alu_src_imm), 32'(e_imm));
      else            chk("R4", "alu_src_imm", 32'(alu_src_imm), 32'(e_imm));
      // R5..R8 constant widening
      case (e_kind)
         1: chk("R5", "imm_ext", imm_ext, e_ext);
         2: chk("R6", "imm_ext", imm_ext, e_ext);
         3: chk("R7", "imm_ext", imm_ext, e_ext);
         default: chk("R8", "imm_ext", imm_ext, e_ext);
      endcase
      // R9 overflow trap
      chk("R9", "ovf_trap", 32'(ovf_trap), 32'(e_ovf));
      // R10 write-back
      chk("R10", "reg_we",  32'(reg_we),     32'(e_we));
      chk("R10", "dst_sel", 32'(dst_sel_rd), 32'(e_rd_dst));
      chk("R10", "dst_idx", 32'(dst_idx),    e_rd_dst ? 32'(w[15:11]) : 32'(w[20:16]));
      // R11 memory
      chk("R11", "mem_rd",    32'(mem_rd),    32'(e_mrd));
      chk("R11", "mem_we",    32'(mem_we),    32'(e_mwe));
      chk("R11", "mem_byte",  32'(mem_byte),  32'(e_byte));
      chk("R11", "load_zext", 32'(load_zext), 32'(e_zx));
      // R12 illegal words are inert
      if (e_fmt == 3) begin
         chk("R12", "side_effects",
             32'({reg_we, mem_rd, mem_we, mem_byte, load_zext, ovf_trap, alu_src_imm, dst_sel_rd}),
             32'd0);
         chk("R12", "alu_op", 32'(alu_op), 32'd0);
      end
   endtask

   task automatic apply(input logic [31:0] w);
      @(posedge clk);
      instr = w;
      @(negedge clk);
      compare_word(w);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      int legal_ops[10] = '{8, 9, 12, 13, 15, 35, 32, 36, 43, 40};
      int legal_fns[11] = '{32, 33, 34, 35, 36, 37, 38, 39, 0, 2, 3};

      // reset phase: all-zero word decodes as a register-class left shift
      repeat (3) begin
         @(negedge clk);
         compare_word(32'h0);
      end
      rst = 1'b0;

      // directed words
      apply(32'h21840021);              // R5 add-immediate rs12 rt4 imm 33
      chk("R1", "example rs", 32'(rs_idx), 32'd12);
      chk("R1", "example rt", 32'(rt_idx), 32'd4);
      chk("R5", "example imm", imm_ext, 32'd33);
      apply(mk_r(8, 9, 7, 0, 34));      // R3 subtract with trap
      apply(mk_r(8, 9, 7, 0, 35));      // R9 subtract without trap
      apply(mk_r(1, 2, 3, 0, 32));
      apply(mk_r(1, 2, 3, 0, 33));
      for (int k = 36; k <= 39; k++) apply(mk_r(k - 30, 31, 17, 0, k));
      apply(mk_r(0, 5, 6, 3, 0));       // shifts
      apply(mk_r(0, 5, 6, 31, 2));
      apply(mk_r(0, 5, 6, 7, 3));
      apply(mk_i(8, 8, 4, 16'hFFEC));   // negative sign extension
      apply(mk_i(9, 8, 4, 16'hFFEC));   // R6 zero extension
      apply(mk_i(12, 8, 4, 16'h8001));
      apply(mk_i(13, 9, 4, 16'hABCD));
      apply(mk_i(15, 0, 8, 16'h1B23));  // R7
      apply(mk_i(15, 0, 8, 16'hFFFF));
      apply(mk_i(35, 29, 14, 8));       // R11 loads and stores
      apply(mk_i(32, 29, 14, 16'h8000));
      apply(mk_i(36, 29, 14, 16'h8000));
      apply(mk_i(43, 29, 14, 16'hFFF8));
      apply(mk_i(40, 29, 14, 16'h7FFF));
      apply(mk_i(2, 3, 4, 16'h1234));   // R12 illegal opcodes
      apply(mk_i(63, 31, 31, 16'hFFFF));
      apply(mk_i(10, 1, 1, 16'h8000));
      apply(mk_r(31, 31, 31, 31, 8));   // R12 illegal function codes
      apply(mk_r(3, 4, 5, 0, 42));
      apply(mk_r(3, 4, 5, 0, 1));
      apply(mk_r(3, 4, 5, 0, 63));

      // weighted random words
      for (int n = 0; n < N_RAND; n++) begin
         logic [31:0] w;
         int sel;
         w   = $urandom;
         sel = $urandom_range(0, 9);
         if (sel < 4)
            w[31:26] = 6'(legal_ops[$urandom_range(0, 9)]);
         else if (sel < 8) begin
            w[31:26] = 6'd0;
            w[5:0]   = 6'(legal_fns[$urandom_range(0, 10)]);
         end else if (sel == 8)
            w[31:26] = 6'd0;
         apply(w);
      end

      finish_run();
   end

   // watchdog
   initial begin
      #(CLK_PERIOD * 200000);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule